// File: doc/BRIEF.md
# I2C Digital Potentiometer Wiper Controller

This block is an I2C target that holds the tap position of a digital potentiometer. A bus host can set the position, read it back, copy it into a nonvolatile cell, and read back either the stored copy or a factory tolerance word that is kept beside it. After reset the block loads the position from the nonvolatile copy before it answers any bus traffic. While a copy into the nonvolatile cell is in progress, the block stays silent on the bus.

The bus pins are sampled through synchronizers. START and STOP are found on the synchronized edges. SDA is driven open-drain, and the block only ever pulls it low. On the memory side the block issues a one-cycle request and watches a busy flag that the memory raises. The long programming time is counted inside the block, using a cycle count that is derived from the clock frequency.

A host frame is built from three bytes: the address byte, a command byte whose upper nibble picks the operation, and an optional data byte. A read is prepared by writing a read command. The host then sends a repeated START with the read bit set and clocks the result out.

Top module: `i2c_wiper_ctrl`

## Requirements
- R1: The block acknowledges the address byte only when its upper seven bits equal 0101111 with `addr_sel`=0, or 0101100 with `addr_sel`=1. Any other address, including the general call 0000000 and the 11110xx prefix used for 10-bit addressing, gets no acknowledge.
- R2: A START (SDA falls while SCL is high) begins a new frame at the address byte from any state, and this includes a repeated START. A STOP (SDA rises while SCL is high) abandons the frame.
- R3: The block only pulls SDA low and never drives it high. Its SDA drive changes only while SCL is low.
- R4: A write frame with command nibble 0x2 followed by a data byte sets `wiper` to data[WIPER_W-1:0]. Each accepted byte is acknowledged on the ninth clock.
- R5: After command nibble 0x3, a read frame returns the wiper position zero-extended to 8 bits, MSB first. The same byte is repeated while the host acknowledges. After a host NACK the block releases SDA.
- R6: Command nibble 0x1 issues exactly one memory write request, with `nv_sel`=0 and `nv_wdata` equal to the zero-extended wiper.
- R7: For STORE_US microseconds after a store command, no address byte is acknowledged and `wiper` does not change.
- R8: Command nibble 0x6 makes the next read return memory location 0 (the stored position). Command nibble 0x7 makes it return location 1 (the tolerance word). Neither command changes `wiper`.
- R9: After reset, `wiper` is loaded from memory location 0. SDA stays released until that load completes.
- R10: `nv_req` is a one-cycle pulse, raised only while `nv_busy` is low.
- R11: The command nibbles 0x0, 0x4, 0x5 and 0x8 to 0xF are acknowledged and have no effect on `wiper`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr_sel | input | 1 | Static strap that picks one of the two target addresses |
| scl_i | input | 1 | I2C clock line, as sampled |
| sda_i | input | 1 | I2C data line, as sampled |
| sda_oe | output | 1 | When high, SDA is pulled low (open-drain) |
| wiper | output | WIPER_W | Current wiper position |
| nv_req | output | 1 | One-cycle memory request |
| nv_we | output | 1 | The request is a write |
| nv_sel | output | 1 | Memory location: 0 for the position copy, 1 for the tolerance |
| nv_wdata | output | 8 | Write data |
| nv_busy | input | 1 | Memory is working on a request |
| nv_rdata | input | 8 | Read data, valid when busy falls |

## Verification
The assertions are checked on every cycle and cover the following:
- the SDA drive only moves while SCL is low;
- the memory request is a single pulse that is never raised over a busy memory;
- SDA stays released during the power-up load;
- the wiper holds and no new acknowledge starts during the store window.

Only the bench scenarios can show the rest:
- address decoding across all 128 addresses and both strap settings;
- write and read-back of the wiper across its range;
- the values returned by the stored-copy and tolerance reads;
- that a store reaches memory and survives a reset.

// File: rtl/wiper_pkg.sv
package wiper_pkg;

    localparam logic [6:0] TGT_ADDR_0 = 7'b0101111;
    localparam logic [6:0] TGT_ADDR_1 = 7'b0101100;

    localparam logic [3:0] OP_STORE  = 4'h1;
    localparam logic [3:0] OP_SET    = 4'h2;
    localparam logic [3:0] OP_RD_POS = 4'h3;
    localparam logic [3:0] OP_RD_NV  = 4'h6;
    localparam logic [3:0] OP_RD_TOL = 4'h7;

    typedef enum logic [2:0] {
        BUS_IDLE,
        BUS_RX,
        BUS_RXEND,
        BUS_ACK,
        BUS_TX,
        BUS_TXACK,
        BUS_SKIP
    } bus_st_e;

    typedef enum logic [2:0] {
        MEM_IDLE,
        MEM_REQ,
        MEM_WHI,
        MEM_WLO,
        MEM_HOLD
    } mem_st_e;

    typedef enum logic [1:0] {
        JOB_RESTORE,
        JOB_STORE,
        JOB_FETCH
    } mem_job_e;

endpackage

// File: rtl/wiper_i2c_sync.sv
module wiper_i2c_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    typedef struct packed {
        logic [SYNC_STAGES-1:0] scl_ff;
        logic [SYNC_STAGES-1:0] sda_ff;
        logic                   scl_p;
        logic                   sda_p;
    } sync_t;

    sync_t s_d, s_q;

    assign scl_s = s_q.scl_ff[SYNC_STAGES-1];
    assign sda_s = s_q.sda_ff[SYNC_STAGES-1];

    always_comb begin
        s_d        = s_q;
        s_d.scl_ff = {s_q.scl_ff[SYNC_STAGES-2:0], scl_i};
        s_d.sda_ff = {s_q.sda_ff[SYNC_STAGES-2:0], sda_i};
        s_d.scl_p  = scl_s;
        s_d.sda_p  = sda_s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{scl_ff: '1, sda_ff: '1, scl_p: 1'b1, sda_p: 1'b1};
        end else begin
            s_q <= s_d;
        end
    end

    assign scl_rise  = scl_s & ~s_q.scl_p;
    assign scl_fall  = ~scl_s & s_q.scl_p;
    assign start_det = scl_s & s_q.scl_p & s_q.sda_p & ~sda_s;
    assign stop_det  = scl_s & s_q.scl_p & ~s_q.sda_p & sda_s;

endmodule

// File: rtl/wiper_nv_seq.sv
module wiper_nv_seq
    import wiper_pkg::*;
#(
    parameter int WIPER_W      = 7,
    parameter int STORE_CYCLES = 900_000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               store_go,
    input  logic               fetch_go,
    input  logic               fetch_sel,
    input  logic [WIPER_W-1:0] wiper,
    input  logic               nv_busy,
    input  logic [7:0]         nv_rdata,
    output logic               nv_req,
    output logic               nv_we,
    output logic               nv_sel,
    output logic [7:0]         nv_wdata,
    output logic               locked,
    output logic               boot_lock,
    output logic               load_vld,
    output logic               fetch_vld,
    output logic [7:0]         rd_data
);
    localparam int CNT_W = $clog2(STORE_CYCLES + 1);

    typedef struct packed {
        mem_st_e    st;
        mem_job_e   job;
        logic       sel;
        logic [CNT_W-1:0] cnt;
    } seq_t;

    seq_t q_d, q_q;

    always_comb begin
        q_d       = q_q;
        load_vld  = 1'b0;
        fetch_vld = 1'b0;
        if (q_q.cnt != '0) q_d.cnt = q_q.cnt - CNT_W'(1);
        case (q_q.st)
            MEM_IDLE: begin
                if (store_go) begin
                    q_d.st  = MEM_REQ;
                    q_d.job = JOB_STORE;
                    q_d.sel = 1'b0;
                    q_d.cnt = CNT_W'(STORE_CYCLES);
                end else if (fetch_go) begin
                    q_d.st  = MEM_REQ;
                    q_d.job = JOB_FETCH;
                    q_d.sel = fetch_sel;
                end
            end
            MEM_REQ:  if (!nv_busy) q_d.st = MEM_WHI;
            MEM_WHI:  if (nv_busy) q_d.st = MEM_WLO;
            MEM_WLO: begin
                if (!nv_busy) begin
                    case (q_q.job)
                        JOB_RESTORE: begin load_vld = 1'b1;  q_d.st = MEM_IDLE; end
                        JOB_FETCH:   begin fetch_vld = 1'b1; q_d.st = MEM_IDLE; end
                        default:     q_d.st = MEM_HOLD;
                    endcase
                end
            end
            MEM_HOLD: if (q_q.cnt == '0) q_d.st = MEM_IDLE;
            default:  q_d.st = MEM_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_q <= '{st: MEM_REQ, job: JOB_RESTORE, sel: 1'b0, cnt: '0};
        end else begin
            q_q <= q_d;
        end
    end

    assign nv_req    = (q_q.st == MEM_REQ) && !nv_busy;
    assign nv_we     = (q_q.job == JOB_STORE);
    assign nv_sel    = q_q.sel;
    assign nv_wdata  = 8'(wiper);
    assign locked    = (q_q.st != MEM_IDLE) && (q_q.job != JOB_FETCH);
    assign boot_lock = (q_q.st != MEM_IDLE) && (q_q.job == JOB_RESTORE);
    assign rd_data   = nv_rdata;

endmodule

// File: rtl/i2c_wiper_ctrl.sv
module i2c_wiper_ctrl
    import wiper_pkg::*;
#(
    parameter int WIPER_W     = 7,
    parameter int CLK_HZ      = 50_000_000,
    parameter int STORE_US    = 18_000,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               addr_sel,
    input  logic               scl_i,
    input  logic               sda_i,
    output logic               sda_oe,
    output logic [WIPER_W-1:0] wiper,
    output logic               nv_req,
    output logic               nv_we,
    output logic               nv_sel,
    output logic [7:0]         nv_wdata,
    input  logic               nv_busy,
    input  logic [7:0]         nv_rdata
);
    localparam int STORE_CYCLES = (CLK_HZ / 1_000_000) * STORE_US;

    typedef struct packed {
        bus_st_e            st;
        logic [2:0]         cnt;
        logic [7:0]         shift;
        logic [1:0]         bidx;
        logic               rw;
        logic [3:0]         op;
        logic               macked;
        logic [7:0]         rd_byte;
        logic [WIPER_W-1:0] pos;
    } bus_t;

    bus_t b_d, b_q;

    logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic store_go, fetch_go, fetch_sel;
    logic locked, boot_lock, store_lock, load_vld, fetch_vld;
    logic [7:0] seq_rdata;
    logic [6:0] own_addr;

    wiper_i2c_sync #(.SYNC_STAGES(SYNC_STAGES)) sync_i (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    wiper_nv_seq #(.WIPER_W(WIPER_W), .STORE_CYCLES(STORE_CYCLES)) seq_i (
        .clk(clk), .rst_n(rst_n), .store_go(store_go), .fetch_go(fetch_go),
        .fetch_sel(fetch_sel), .wiper(b_q.pos), .nv_busy(nv_busy), .nv_rdata(nv_rdata),
        .nv_req(nv_req), .nv_we(nv_we), .nv_sel(nv_sel), .nv_wdata(nv_wdata),
        .locked(locked), .boot_lock(boot_lock), .load_vld(load_vld),
        .fetch_vld(fetch_vld), .rd_data(seq_rdata)
    );

    assign own_addr   = addr_sel ? TGT_ADDR_1 : TGT_ADDR_0;
    assign store_lock = locked & ~boot_lock;

    always_comb begin
        b_d       = b_q;
        store_go  = 1'b0;
        fetch_go  = 1'b0;
        fetch_sel = 1'b0;
        if (load_vld)  b_d.pos     = WIPER_W'(seq_rdata);
        if (fetch_vld) b_d.rd_byte = seq_rdata;
        if (start_det) begin
            b_d.st   = BUS_RX;
            b_d.cnt  = '0;
            b_d.bidx = '0;
            b_d.rw   = 1'b0;
        end else if (stop_det) begin
            b_d.st = BUS_IDLE;
        end else begin
            case (b_q.st)
                BUS_RX: begin
                    if (scl_rise) begin
                        b_d.shift = {b_q.shift[6:0], sda_s};
                        b_d.cnt   = b_q.cnt + 3'd1;
                        if (b_q.cnt == 3'd7) b_d.st = BUS_RXEND;
                    end
                end
                BUS_RXEND: begin
                    if (scl_fall) begin
                        b_d.st = BUS_SKIP;
                        if (!locked) begin
                            if (b_q.bidx == 2'd0) begin
                                if (b_q.shift[7:1] == own_addr) begin
                                    b_d.st = BUS_ACK;
                                    b_d.rw = b_q.shift[0];
                                end
                            end else begin
                                b_d.st = BUS_ACK;
                                if (b_q.bidx == 2'd1) begin
                                    b_d.op = b_q.shift[7:4];
                                    case (b_q.shift[7:4])
                                        OP_STORE:  store_go = 1'b1;
                                        OP_RD_POS: b_d.rd_byte = 8'(b_q.pos);
                                        OP_RD_NV:  fetch_go = 1'b1;
                                        OP_RD_TOL: begin fetch_go = 1'b1; fetch_sel = 1'b1; end
                                        default:   ;
                                    endcase
                                end else if (b_q.bidx == 2'd2 && b_q.op == OP_SET) begin
                                    b_d.pos = b_q.shift[WIPER_W-1:0];
                                end
                            end
                            if (b_q.bidx != 2'd3) b_d.bidx = b_q.bidx + 2'd1;
                        end
                    end
                end
                BUS_ACK: begin
                    if (scl_fall) begin
                        b_d.cnt = '0;
                        if (b_q.rw) begin
                            b_d.st    = BUS_TX;
                            b_d.shift = b_q.rd_byte;
                        end else begin
                            b_d.st = BUS_RX;
                        end
                    end
                end
                BUS_TX: begin
                    if (scl_fall) begin
                        if (b_q.cnt == 3'd7) begin
                            b_d.st = BUS_TXACK;
                        end else begin
                            b_d.shift = {b_q.shift[6:0], 1'b0};
                            b_d.cnt   = b_q.cnt + 3'd1;
                        end
                    end
                end
                BUS_TXACK: begin
                    if (scl_rise) b_d.macked = ~sda_s;
                    if (scl_fall) begin
                        if (b_q.macked) begin
                            b_d.st    = BUS_TX;
                            b_d.shift = b_q.rd_byte;
                            b_d.cnt   = '0;
                        end else begin
                            b_d.st = BUS_SKIP;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            b_q <= '{st: BUS_IDLE, cnt: '0, shift: '0, bidx: '0, rw: 1'b0, op: '0,
                     macked: 1'b0, rd_byte: '0, pos: '0};
        end else begin
            b_q <= b_d;
        end
    end

    assign sda_oe = (b_q.st == BUS_ACK) || ((b_q.st == BUS_TX) && !b_q.shift[7]);
    assign wiper  = b_q.pos;

endmodule

// File: rtl/wiper_ctrl_chk.sv
module wiper_ctrl_chk #(
    parameter int WIPER_W = 7
) (
    input logic               clk,
    input logic               rst_n,
    input logic               scl_i,
    input logic               sda_oe,
    input logic [WIPER_W-1:0] wiper,
    input logic               nv_req,
    input logic               nv_busy,
    input logic               store_lock,
    input logic               boot_lock
);
    // R3
    sda_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !scl_i);

    // R10
    nv_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        nv_req |=> !nv_req);

    // R10
    nv_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        nv_req |-> !nv_busy);

    // R9
    boot_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        boot_lock |-> !sda_oe);

    // R7
    store_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (store_lock && $past(store_lock)) |-> $stable(wiper));

    // R7
    store_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (store_lock && $past(store_lock)) |-> !$rose(sda_oe));

endmodule

bind i2c_wiper_ctrl wiper_ctrl_chk #(.WIPER_W(WIPER_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_oe(sda_oe), .wiper(wiper),
    .nv_req(nv_req), .nv_busy(nv_busy), .store_lock(store_lock), .boot_lock(boot_lock)
);

// File: tb/i2c_wiper_ctrl_tb_top.sv
`timescale 1ns/1ps
module i2c_wiper_ctrl_tb_top;
    localparam int WW = 7;
    localparam int Q  = 5;
    localparam logic [6:0] AD0 = 7'b0101111;
    localparam logic [6:0] AD1 = 7'b0101100;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic addr_sel = 1'b0;
    logic scl_m = 1'b1;
    logic sda_low = 1'b0;
    logic sda_oe;
    logic [WW-1:0] wiper;
    logic nv_req, nv_we, nv_sel;
    logic [7:0] nv_wdata;
    logic nv_busy = 1'b0;
    logic [7:0] nv_rdata = 8'h00;
    logic sda_line;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;
    assign sda_line = !(sda_low || sda_oe);

    i2c_wiper_ctrl #(.WIPER_W(WW), .CLK_HZ(50_000_000), .STORE_US(40)) dut_i (
        .clk(clk), .rst_n(rst_n), .addr_sel(addr_sel), .scl_i(scl_m), .sda_i(sda_line),
        .sda_oe(sda_oe), .wiper(wiper), .nv_req(nv_req), .nv_we(nv_we), .nv_sel(nv_sel),
        .nv_wdata(nv_wdata), .nv_busy(nv_busy), .nv_rdata(nv_rdata)
    );

    // behavioural nonvolatile memory
    logic [7:0] nv_mem [2];
    int nv_wr_cnt = 0;
    logic [2:0] nv_cnt = 3'd0;
    logic nv_sel_l = 1'b0, nv_we_l = 1'b0;
    logic [7:0] nv_wd_l = 8'h00;
    initial begin
        nv_mem[0] = 8'h25;
        nv_mem[1] = 8'h5A;
    end
    always @(posedge clk) begin
        if (nv_req) begin
            nv_busy  <= 1'b1;
            nv_cnt   <= 3'd4;
            nv_sel_l <= nv_sel;
            nv_we_l  <= nv_we;
            nv_wd_l  <= nv_wdata;
        end else if (nv_busy) begin
            if (nv_cnt == 3'd0) begin
                nv_busy  <= 1'b0;
                nv_rdata <= nv_mem[nv_sel_l];
                if (nv_we_l) begin
                    nv_mem[nv_sel_l] <= nv_wd_l;
                    nv_wr_cnt <= nv_wr_cnt + 1;
                end
            end else begin
                nv_cnt <= nv_cnt - 3'd1;
            end
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    task automatic qw();
        repeat (Q) @(posedge clk);
        #1;
    endtask

    task automatic i2c_start();
        sda_low = 1'b0; scl_m = 1'b1; qw();
        sda_low = 1'b1; qw();
        scl_m = 1'b0; qw();
    endtask

    task automatic i2c_rstart();
        sda_low = 1'b0; qw();
        scl_m = 1'b1; qw();
        sda_low = 1'b1; qw();
        scl_m = 1'b0; qw();
    endtask

    task automatic i2c_stop();
        sda_low = 1'b1; qw();
        scl_m = 1'b1; qw();
        sda_low = 1'b0; qw();
    endtask

    task automatic send_bit(input logic b);
        sda_low = !b; qw();
        scl_m = 1'b1; qw(); qw();
        scl_m = 1'b0; qw();
    endtask

    task automatic recv_bit(output logic b);
        sda_low = 1'b0; qw();
        scl_m = 1'b1; qw();
        b = sda_line; qw();
        scl_m = 1'b0; qw();
    endtask

    task automatic wr_byte(input logic [7:0] v, output logic ack);
        logic b;
        for (int i = 7; i >= 0; i--) send_bit(v[i]);
        recv_bit(b);
        ack = !b;
    endtask

    task automatic rd_byte(input logic mack, output logic [7:0] v);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            recv_bit(b);
            v[i] = b;
        end
        send_bit(!mack);
    endtask

    task automatic wr_frame(input logic [6:0] a, input logic [7:0] cmd, input logic [7:0] dat,
                            output logic a0, output logic a1, output logic a2);
        i2c_start();
        wr_byte({a, 1'b0}, a0);
        wr_byte(cmd, a1);
        wr_byte(dat, a2);
        i2c_stop();
    endtask

    task automatic rd_frame(input logic [7:0] cmd, output logic [7:0] v0, output logic [7:0] v1,
                            output logic ok);
        logic x0, x1, x2;
        i2c_start();
        wr_byte({AD0, 1'b0}, x0);
        wr_byte(cmd, x1);
        i2c_rstart();
        wr_byte({AD0, 1'b1}, x2);
        rd_byte(1'b1, v0);
        rd_byte(1'b0, v1);
        i2c_stop();
        ok = x0 & x1 & x2;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic a0, a1, a2, ok;
        logic [7:0] v0, v1;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        repeat (50) @(posedge clk);
        #1;
        chk("R9 restore after reset", int'(wiper), 'h25);
        chk("R9 sda released", int'(sda_line), 1);

        // R1: sweep every address with strap 0
        for (int a = 0; a < 128; a++) begin
            i2c_start();
            wr_byte({7'(a), 1'b0}, a0);
            i2c_stop();
            chk($sformatf("R1 addr %0h", a), int'(a0), (7'(a) == AD0) ? 1 : 0);
        end
        addr_sel = 1'b1;
        i2c_start(); wr_byte({AD1, 1'b0}, a0); i2c_stop();
        chk("R1 strap1 alt addr", int'(a0), 1);
        i2c_start(); wr_byte({AD0, 1'b0}, a0); i2c_stop();
        chk("R1 strap1 other addr", int'(a0), 0);
        addr_sel = 1'b0;

        // R2: aborted frame followed by a clean one
        i2c_start();
        for (int i = 0; i < 4; i++) send_bit(1'b0);
        i2c_stop();
        wr_frame(AD0, 8'h20, 8'h33, a0, a1, a2);
        chk("R2 frame after stop", int'({a0, a1, a2}), 7);
        chk("R2 value after stop", int'(wiper), 'h33);

        // R4/R5 sweep
        for (int v = 0; v < 128; v += 3) begin
            wr_frame(AD0, 8'h2F, 8'(v), a0, a1, a2);
            chk("R4 acks", int'({a0, a1, a2}), 7);
            chk("R4 wiper", int'(wiper), v);
            rd_frame(8'h30, v0, v1, ok);
            chk("R5 read first", int'(v0), v);
            chk("R5 read repeat", int'(v1), v);
        end
        wr_frame(AD0, 8'h20, 8'hFF, a0, a1, a2);
        chk("R4 top value", int'(wiper), 127);
        repeat (20) @(posedge clk);
        #1 chk("R5 sda released after nack", int'(sda_line), 1);

        // R11: unused commands
        wr_frame(AD0, 8'h40, 8'h05, a0, a1, a2);
        chk("R11 cmd4 acked", int'({a1, a2}), 3);
        chk("R11 cmd4 no effect", int'(wiper), 127);
        wr_frame(AD0, 8'h0A, 8'h05, a0, a1, a2);
        wr_frame(AD0, 8'hF1, 8'h05, a0, a1, a2);
        chk("R11 cmd0/F no effect", int'(wiper), 127);

        // R6/R7: store
        wr_frame(AD0, 8'h20, 8'h55, a0, a1, a2);
        i2c_start(); wr_byte({AD0, 1'b0}, a0); wr_byte(8'h10, a1); i2c_stop();
        chk("R6 store acked", int'(a1), 1);
        i2c_start(); wr_byte({AD0, 1'b0}, a0); i2c_stop();
        chk("R7 addr refused while storing", int'(a0), 0);
        wr_frame(AD0, 8'h20, 8'h0A, a0, a1, a2);
        chk("R7 write refused", int'(a0), 0);
        chk("R7 wiper held", int'(wiper), 'h55);
        repeat (2500) @(posedge clk);
        #1;
        chk("R6 memory content", int'(nv_mem[0]), 'h55);
        chk("R6 one write", nv_wr_cnt, 1);
        i2c_start(); wr_byte({AD0, 1'b0}, a0); i2c_stop();
        chk("R7 addr acked after window", int'(a0), 1);

        // R8: stored copy and tolerance
        wr_frame(AD0, 8'h20, 8'h11, a0, a1, a2);
        rd_frame(8'h60, v0, v1, ok);
        chk("R8 stored copy", int'(v0), 'h55);
        rd_frame(8'h70, v0, v1, ok);
        chk("R8 tolerance", int'(v0), 'h5A);
        chk("R8 wiper untouched", int'(wiper), 'h11);

        // R9: reset restores stored value
        #1 rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        repeat (50) @(posedge clk);
        #1 chk("R9 restore stored", int'(wiper), 'h55);
        chk("R6 no extra write", nv_wr_cnt, 1);

        finish_run();
    end

endmodule